// File: doc/BRIEF.md
# Indirect Target Tagged Predictor Lookup

This block predicts the destination address of one indirect jump per clock cycle. It holds five tagged tables of target entries. Tables 1 and 2 have 256 entries each, and tables 3, 4 and 5 have 512 entries each. A higher table number means the table uses a longer global history.

For each table, the caller supplies three folded histories: one for the index and two for the tag. The block hashes each of them with the request PC, reads every table in parallel and decides which tables hit. From the hits it picks a provider and an alternate. It then returns a target, which comes either from one of the tables or from a fallback address that the caller supplies.

The result appears three clock edges after the request. It carries the provider and alternate table numbers, their confidence counters and the provider's useful bit, which a later training step can use. A simple write port preloads or overwrites single entries. Computing the folded histories and training the tables are the caller's job.

Top module: `ind_target_pred`

## Requirements
- R1: A request sampled with `req_valid` high produces `out_valid` high for exactly one cycle, three rising edges later. Requests on consecutive cycles produce results on consecutive cycles.
- R2: A table hits only when the addressed entry's valid bit is set and its stored 9-bit tag equals the computed tag. Otherwise the table misses.
- R3: The index of table t is (PC >> 1) XOR the index history masked to its low 4, 8, 9, 9 or 9 bits (tables 1 to 5). The result is cut to 8 bits for tables 1–2 and to 9 bits for tables 3–5. History bits above the mask have no effect.
- R4: The tag is bits 8:0 of (PC >> 1), XOR the first tag history masked to 4, 8, 9, 9 or 9 bits, XOR the second tag history masked to 4, 8, 8, 8 or 8 bits and shifted left by one.
- R5: The provider is the highest-numbered hitting table. The alternate is the next-highest hitting table. Table numbers on `out_prov_id` and `out_alt_id` are 1 to 5, and 0 means none. `out_hit` is high exactly when a provider exists.
- R6: When the provider's counter is nonzero, the provider's entry supplies the target and `out_use_table` is 1.
- R7: When the provider's counter is zero, the alternate's entry supplies the target if an alternate exists. Otherwise the fallback target is used and `out_use_table` is 0.
- R8: When no table hits, `out_target` equals the request's `fb_target` and `out_use_table` is 0.
- R9: A target taken from a table is {`req_pc[49:20]`, the stored 20-bit offset}.
- R10: A write with `wr_en` and `wr_tab` = n (1 to 5) stores the valid bit, tag, counter, offset and useful bit at the low index bits of `wr_idx` in table n only. Writing the valid bit as 0 removes the entry.
- R11: `out_target_ok` equals `out_use_table` OR the request's `fb_valid`.
- R12: After reset, every output is zero and every entry is invalid.
- R13: `out_prov_ctr` and `out_prov_useful` report the provider entry's counter and useful bit, and `out_alt_ctr` reports the alternate's counter. Each is zero when the corresponding table is absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_pc | input | 50 | PC of the indirect jump |
| hist_idx | input | 5x9 | Folded index history per table |
| hist_tag1 | input | 5x9 | First folded tag history per table |
| hist_tag2 | input | 5x8 | Second folded tag history per table |
| fb_target | input | 50 | Fallback target for misses |
| fb_valid | input | 1 | Fallback target is meaningful |
| wr_en | input | 1 | Entry write strobe |
| wr_tab | input | 3 | Table number to write (1 to 5) |
| wr_idx | input | 9 | Entry index to write |
| wr_vld | input | 1 | Valid bit to store |
| wr_tag | input | 9 | Tag to store |
| wr_ctr | input | 2 | Confidence counter to store |
| wr_off | input | 20 | Target offset to store |
| wr_useful | input | 1 | Useful bit to store |
| out_valid | output | 1 | Result valid |
| out_target | output | 50 | Predicted target |
| out_target_ok | output | 1 | Target is usable |
| out_hit | output | 1 | Some table hit |
| out_use_table | output | 1 | Target came from a table |
| out_prov_id | output | 3 | Provider table number, 0 for none |
| out_prov_ctr | output | 2 | Provider counter |
| out_prov_useful | output | 1 | Provider useful bit |
| out_alt_id | output | 3 | Alternate table number, 0 for none |
| out_alt_ctr | output | 2 | Alternate counter |

## Verification
On every cycle, the bound checker enforces these rules:
- the fixed three-edge latency;
- the ordering rule that keeps the alternate below the provider;
- the choice of source from the provider counter;
- the fallback path on a miss;
- the origin of the upper target bits;
- the ok flag;
- zeroed reports when no table exists.

Whether the hashes reach the right entry, and whether the tag masks and the shift behave, only the bench's scenarios can show. The same holds for whether a chosen offset belongs to the correct table and whether a write invalidates an entry. For these, the bench preloads entries at computed indices and then changes single history bits.

// File: rtl/itp_pkg.sv
`timescale 1ns/1ps
package itp_pkg;
    parameter int NT    = 5;
    parameter int PC_W  = 50;
    parameter int OFF_W = 20;
    parameter int TAG_W = 9;
    parameter int CTR_W = 2;
    parameter int HW    = 9;
    parameter int H2W   = TAG_W - 1;
    parameter int ID_W  = $clog2(NT + 1);
    parameter int REG_W = PC_W - OFF_W;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [CTR_W-1:0] ctr;
        logic [OFF_W-1:0] off;
        logic             useful;
    } ent_t;

    typedef enum logic [1:0] {
        SRC_FALLBACK = 2'd0,
        SRC_PROVIDER = 2'd1,
        SRC_ALTPRED  = 2'd2
    } src_e;

    function automatic int tab_depth(input int t);
        return (t < 2) ? 256 : 512;
    endfunction

    function automatic int idx_hist_w(input int t);
        case (t)
            0:       return 4;
            1:       return 8;
            default: return 9;
        endcase
    endfunction

    function automatic int tag2_hist_w(input int t);
        case (t)
            0:       return 4;
            default: return 8;
        endcase
    endfunction
endpackage

// File: rtl/itp_table.sv
`timescale 1ns/1ps
module itp_table
    import itp_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int IDX_HW = 4,
    parameter int T1_W   = 4,
    parameter int T2_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [HW-1:0]    pc_h,
    input  logic [HW-1:0]    hist_idx,
    input  logic [HW-1:0]    hist_tag1,
    input  logic [H2W-1:0]   hist_tag2,
    input  logic             wr_en,
    input  logic [HW-1:0]    wr_idx,
    input  ent_t             wr_ent,
    input  logic             wr_vld,
    output logic             hit,
    output logic [CTR_W-1:0] rd_ctr,
    output logic [OFF_W-1:0] rd_off,
    output logic             rd_useful
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam logic [HW-1:0]  IDX_MASK  = HW'((1 << IDX_HW) - 1);
    localparam logic [HW-1:0]  TAG1_MASK = HW'((1 << T1_W) - 1);
    localparam logic [H2W-1:0] TAG2_MASK = H2W'((1 << T2_W) - 1);

    ent_t             mem [DEPTH];
    logic [DEPTH-1:0] vld_q;
    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] wr_sel;
    logic [TAG_W-1:0] tag_c;
    logic [TAG_W-1:0] tag_q;
    logic             rd_vld_q;
    ent_t             rd_ent;
    logic             wr_idx_unused;

    assign rd_idx        = IDX_W'(pc_h ^ (hist_idx & IDX_MASK));
    assign tag_c         = pc_h ^ (hist_tag1 & TAG1_MASK) ^ {(hist_tag2 & TAG2_MASK), 1'b0};
    assign wr_sel        = wr_idx[IDX_W-1:0];
    assign wr_idx_unused = ^wr_idx;

    // array body: synchronous read, no reset
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_sel] <= wr_ent;
        end
        if (rd_en) begin
            rd_ent <= mem[rd_idx];
        end
    end

    // valid bits and the compare tag are reset so that no stale entry hits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q    <= '0;
            rd_vld_q <= 1'b0;
            tag_q    <= '0;
        end else begin
            if (wr_en) begin
                vld_q[wr_sel] <= wr_vld;
            end
            if (rd_en) begin
                rd_vld_q <= vld_q[rd_idx];
                tag_q    <= tag_c;
            end
        end
    end

    assign hit       = rd_vld_q && (rd_ent.tag == tag_q);
    assign rd_ctr    = rd_ent.ctr;
    assign rd_off    = rd_ent.off;
    assign rd_useful = rd_ent.useful;
endmodule

// File: rtl/itp_select.sv
`timescale 1ns/1ps
module itp_select
    import itp_pkg::*;
(
    input  logic [NT-1:0]            hit,
    input  logic [NT-1:0][CTR_W-1:0] ctr,
    output logic [ID_W-1:0]          prov_id,
    output logic [CTR_W-1:0]         prov_ctr,
    output logic [ID_W-1:0]          alt_id,
    output logic [CTR_W-1:0]         alt_ctr,
    output src_e                     src
);
    // walk from short to long history; each new hit demotes the previous one
    always_comb begin
        prov_id  = '0;
        prov_ctr = '0;
        alt_id   = '0;
        alt_ctr  = '0;
        for (int t = 0; t < NT; t++) begin
            if (hit[t]) begin
                alt_id   = prov_id;
                alt_ctr  = prov_ctr;
                prov_id  = ID_W'(t + 1);
                prov_ctr = ctr[t];
            end
        end
    end

    always_comb begin
        if (prov_id == '0) begin
            src = SRC_FALLBACK;
        end else if (prov_ctr != '0) begin
            src = SRC_PROVIDER;
        end else if (alt_id != '0) begin
            src = SRC_ALTPRED;
        end else begin
            src = SRC_FALLBACK;
        end
    end
endmodule

// File: rtl/ind_target_pred.sv
`timescale 1ns/1ps
module ind_target_pred
    import itp_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [PC_W-1:0]         req_pc,
    input  logic [NT-1:0][HW-1:0]   hist_idx,
    input  logic [NT-1:0][HW-1:0]   hist_tag1,
    input  logic [NT-1:0][H2W-1:0]  hist_tag2,
    input  logic [PC_W-1:0]         fb_target,
    input  logic                    fb_valid,
    input  logic                    wr_en,
    input  logic [ID_W-1:0]         wr_tab,
    input  logic [HW-1:0]           wr_idx,
    input  logic                    wr_vld,
    input  logic [TAG_W-1:0]        wr_tag,
    input  logic [CTR_W-1:0]        wr_ctr,
    input  logic [OFF_W-1:0]        wr_off,
    input  logic                    wr_useful,
    output logic                    out_valid,
    output logic [PC_W-1:0]         out_target,
    output logic                    out_target_ok,
    output logic                    out_hit,
    output logic                    out_use_table,
    output logic [ID_W-1:0]         out_prov_id,
    output logic [CTR_W-1:0]        out_prov_ctr,
    output logic                    out_prov_useful,
    output logic [ID_W-1:0]         out_alt_id,
    output logic [CTR_W-1:0]        out_alt_ctr
);
    ent_t                       wr_ent;
    logic [HW-1:0]              pc_h;
    logic                       pc_unused;

    logic [NT-1:0]              tab_hit;
    logic [NT-1:0][CTR_W-1:0]   tab_ctr;
    logic [NT-1:0][OFF_W-1:0]   tab_off;
    logic [NT-1:0]              tab_use;

    // stage 1 side data
    logic                       s1_vld;
    logic [REG_W-1:0]           s1_region;
    logic [PC_W-1:0]            s1_fb;
    logic                       s1_fb_ok;

    // stage 2 registers
    logic                       s2_vld;
    logic [NT-1:0]              s2_hit;
    logic [NT-1:0][CTR_W-1:0]   s2_ctr;
    logic [NT-1:0][OFF_W-1:0]   s2_off;
    logic [NT-1:0]              s2_use;
    logic [REG_W-1:0]           s2_region;
    logic [PC_W-1:0]            s2_fb;
    logic                       s2_fb_ok;

    // selection results
    logic [ID_W-1:0]            sel_prov;
    logic [CTR_W-1:0]           sel_prov_ctr;
    logic [ID_W-1:0]            sel_alt;
    logic [CTR_W-1:0]           sel_alt_ctr;
    src_e                       sel_src;

    logic [OFF_W-1:0]           prov_off;
    logic [OFF_W-1:0]           alt_off;
    logic                       prov_use;
    logic [PC_W-1:0]            n_target;
    logic                       n_target_ok;

    assign wr_ent    = {wr_tag, wr_ctr, wr_off, wr_useful};
    assign pc_h      = req_pc[HW:1];
    assign pc_unused = ^{req_pc[0], req_pc[OFF_W-1:HW+1]};

    // stage 0 hashing and stage 1 array read, one table per iteration
    for (genvar t = 0; t < NT; t++) begin : g_tab
        itp_table #(
            .DEPTH  (tab_depth(t)),
            .IDX_HW (idx_hist_w(t)),
            .T1_W   (idx_hist_w(t)),
            .T2_W   (tag2_hist_w(t))
        ) u_tab (
            .clk       (clk),
            .rst_n     (rst_n),
            .rd_en     (req_valid),
            .pc_h      (pc_h),
            .hist_idx  (hist_idx[t]),
            .hist_tag1 (hist_tag1[t]),
            .hist_tag2 (hist_tag2[t]),
            .wr_en     (wr_en && (wr_tab == ID_W'(t + 1))),
            .wr_idx    (wr_idx),
            .wr_ent    (wr_ent),
            .wr_vld    (wr_vld),
            .hit       (tab_hit[t]),
            .rd_ctr    (tab_ctr[t]),
            .rd_off    (tab_off[t]),
            .rd_useful (tab_use[t])
        );
    end

    itp_select u_sel (
        .hit      (s2_hit),
        .ctr      (s2_ctr),
        .prov_id  (sel_prov),
        .prov_ctr (sel_prov_ctr),
        .alt_id   (sel_alt),
        .alt_ctr  (sel_alt_ctr),
        .src      (sel_src)
    );

    // stage 2 output process: pick the chosen offset and assemble the target
    always_comb begin
        prov_off = '0;
        alt_off  = '0;
        prov_use = 1'b0;
        for (int t = 0; t < NT; t++) begin
            if (sel_prov == ID_W'(t + 1)) begin
                prov_off = s2_off[t];
                prov_use = s2_use[t];
            end
            if (sel_alt == ID_W'(t + 1)) begin
                alt_off = s2_off[t];
            end
        end
        unique case (sel_src)
            SRC_PROVIDER: n_target = {s2_region, prov_off};
            SRC_ALTPRED:  n_target = {s2_region, alt_off};
            SRC_FALLBACK: n_target = s2_fb;
        endcase
        n_target_ok = (sel_src != SRC_FALLBACK) || s2_fb_ok;
    end

    // pipeline register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_vld          <= 1'b0;
            s1_region       <= '0;
            s1_fb           <= '0;
            s1_fb_ok        <= 1'b0;
            s2_vld          <= 1'b0;
            s2_hit          <= '0;
            s2_ctr          <= '0;
            s2_off          <= '0;
            s2_use          <= '0;
            s2_region       <= '0;
            s2_fb           <= '0;
            s2_fb_ok        <= 1'b0;
            out_valid       <= 1'b0;
            out_target      <= '0;
            out_target_ok   <= 1'b0;
            out_hit         <= 1'b0;
            out_use_table   <= 1'b0;
            out_prov_id     <= '0;
            out_prov_ctr    <= '0;
            out_prov_useful <= 1'b0;
            out_alt_id      <= '0;
            out_alt_ctr     <= '0;
        end else begin
            s1_vld          <= req_valid;
            s1_region       <= req_pc[PC_W-1:OFF_W];
            s1_fb           <= fb_target;
            s1_fb_ok        <= fb_valid;
            s2_vld          <= s1_vld;
            s2_hit          <= s1_vld ? tab_hit : '0;
            s2_ctr          <= tab_ctr;
            s2_off          <= tab_off;
            s2_use          <= tab_use;
            s2_region       <= s1_region;
            s2_fb           <= s1_fb;
            s2_fb_ok        <= s1_fb_ok;
            out_valid       <= s2_vld;
            out_target      <= n_target;
            out_target_ok   <= n_target_ok;
            out_hit         <= (sel_prov != '0);
            out_use_table   <= (sel_src != SRC_FALLBACK);
            out_prov_id     <= sel_prov;
            out_prov_ctr    <= sel_prov_ctr;
            out_prov_useful <= prov_use;
            out_alt_id      <= sel_alt;
            out_alt_ctr     <= sel_alt_ctr;
        end
    end
endmodule

// File: rtl/itp_checker.sv
`timescale 1ns/1ps
module itp_checker
    import itp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [PC_W-1:0]   req_pc,
    input logic [PC_W-1:0]   fb_target,
    input logic              fb_valid,
    input logic              out_valid,
    input logic [PC_W-1:0]   out_target,
    input logic              out_target_ok,
    input logic              out_hit,
    input logic              out_use_table,
    input logic [ID_W-1:0]   out_prov_id,
    input logic [CTR_W-1:0]  out_prov_ctr,
    input logic              out_prov_useful,
    input logic [ID_W-1:0]   out_alt_id,
    input logic [CTR_W-1:0]  out_alt_ctr
);
    logic [1:0] cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc <= '0;
        end else if (cyc != 2'd3) begin
            cyc <= cyc + 2'd1;
        end
    end

    a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3) |-> (out_valid == $past(req_valid, 3)));

    a_r5_alt_below_prov: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_alt_id != '0) |-> (out_prov_id > out_alt_id));

    a_r5_hit_flag: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_hit == (out_prov_id != '0)));

    a_r6_confident_provider: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_prov_id != '0 && out_prov_ctr != '0) |-> out_use_table);

    a_r7_lowconf_no_alt: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_prov_id != '0 && out_prov_ctr == '0 && out_alt_id == '0)
        |-> !out_use_table);

    a_r8_miss_fallback: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3 && out_valid && out_prov_id == '0)
        |-> (!out_use_table && out_alt_id == '0 && out_target == $past(fb_target, 3)));

    a_r9_region_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3 && out_valid && out_use_table)
        |-> (out_target[PC_W-1:OFF_W] == $past(req_pc[PC_W-1:OFF_W], 3)));

    a_r11_target_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3 && out_valid) |-> (out_target_ok == (out_use_table || $past(fb_valid, 3))));

    a_r13_absent_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_prov_id == '0) |-> (out_prov_ctr == '0 && !out_prov_useful && out_alt_ctr == '0));
endmodule

bind ind_target_pred itp_checker u_chk (.*);

// File: tb/ind_target_pred_bench.sv
`timescale 1ns/1ps
module ind_target_pred_bench;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [49:0]       req_pc = '0;
    logic [4:0][8:0]   hist_idx = '0;
    logic [4:0][8:0]   hist_tag1 = '0;
    logic [4:0][7:0]   hist_tag2 = '0;
    logic [49:0]       fb_target = '0;
    logic              fb_valid = 1'b0;
    logic              wr_en = 1'b0;
    logic [2:0]        wr_tab = '0;
    logic [8:0]        wr_idx = '0;
    logic              wr_vld = 1'b0;
    logic [8:0]        wr_tag = '0;
    logic [1:0]        wr_ctr = '0;
    logic [19:0]       wr_off = '0;
    logic              wr_useful = 1'b0;
    logic              out_valid;
    logic [49:0]       out_target;
    logic              out_target_ok;
    logic              out_hit;
    logic              out_use_table;
    logic [2:0]        out_prov_id;
    logic [1:0]        out_prov_ctr;
    logic              out_prov_useful;
    logic [2:0]        out_alt_id;
    logic [1:0]        out_alt_ctr;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [49:0] cur_pc;
    logic [49:0] cur_fb;
    logic        cur_fbv;
    logic [8:0]  hi [5];
    logic [8:0]  h1 [5];
    logic [7:0]  h2 [5];

    ind_target_pred u_ind_target_pred (.*);

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    function automatic int idx_w(input int t);
        return (t == 0) ? 4 : (t == 1) ? 8 : 9;
    endfunction
    function automatic int tg2_w(input int t);
        return (t == 0) ? 4 : 8;
    endfunction
    function automatic int dep_w(input int t);
        return (t < 2) ? 8 : 9;
    endfunction

    // R3 index and R4 tag, from the requirement text
    function automatic logic [8:0] f_idx(input int t, input logic [49:0] pc, input logic [8:0] h);
        logic [8:0] ph = pc[9:1];
        logic [8:0] m  = 9'((1 << idx_w(t)) - 1);
        logic [8:0] dm = 9'((1 << dep_w(t)) - 1);
        return (ph ^ (h & m)) & dm;
    endfunction
    function automatic logic [8:0] f_tag(input int t, input logic [49:0] pc,
                                         input logic [8:0] a, input logic [7:0] b);
        logic [8:0] ph = pc[9:1];
        logic [8:0] m1 = 9'((1 << idx_w(t)) - 1);
        logic [7:0] m2 = 8'((1 << tg2_w(t)) - 1);
        return ph ^ (a & m1) ^ {(b & m2), 1'b0};
    endfunction

    // write table tn (1..5) at the slot the current pc/histories select
    task automatic put(input int tn, input logic v, input logic [1:0] c,
                       input logic [19:0] off, input logic u);
        @(negedge clk);
        wr_en     = 1'b1;
        wr_tab    = 3'(tn);
        wr_idx    = f_idx(tn - 1, cur_pc, hi[tn-1]);
        wr_tag    = f_tag(tn - 1, cur_pc, h1[tn-1], h2[tn-1]);
        wr_vld    = v;
        wr_ctr    = c;
        wr_off    = off;
        wr_useful = u;
        @(negedge clk);
        wr_en     = 1'b0;
    endtask

    task automatic drive_req(input logic [49:0] pc);
        req_valid = 1'b1;
        req_pc    = pc;
        fb_target = cur_fb;
        fb_valid  = cur_fbv;
        for (int t = 0; t < 5; t++) begin
            hist_idx[t]  = hi[t];
            hist_tag1[t] = h1[t];
            hist_tag2[t] = h2[t];
        end
    endtask

    // one request, then sample three edges later
    task automatic lookup();
        @(negedge clk);
        drive_req(cur_pc);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R1 out_valid at third edge", 64'(out_valid), 64'd1);
    endtask

    function automatic logic [49:0] tbl_tgt(input logic [49:0] pc, input logic [19:0] off);
        return {pc[49:20], off};
    endfunction

    task automatic t_reset();
        chk("R12 out_valid after reset", 64'(out_valid), 64'd0);
        chk("R12 out_target after reset", 64'(out_target), 64'd0);
        chk("R12 out_hit after reset", 64'(out_hit), 64'd0);
        chk("R12 out_prov_id after reset", 64'(out_prov_id), 64'd0);
        cur_fb = 50'h3_0000_0000_1234; cur_fbv = 1'b1;
        lookup();
        chk("R12 no entry valid after reset", 64'(out_hit), 64'd0);
        chk("R8 miss gives fallback", 64'(out_target), 64'(cur_fb));
        chk("R8 miss use_table", 64'(out_use_table), 64'd0);
        chk("R11 ok from fb_valid", 64'(out_target_ok), 64'd1);
    endtask

    task automatic t_single();
        put(1, 1'b1, 2'd2, 20'hABCDE, 1'b1);
        lookup();
        chk("R2 R3 R4 T1 hit provider", 64'(out_prov_id), 64'd1);
        chk("R5 hit flag", 64'(out_hit), 64'd1);
        chk("R6 use_table", 64'(out_use_table), 64'd1);
        chk("R9 table target", 64'(out_target), 64'(tbl_tgt(cur_pc, 20'hABCDE)));
        chk("R13 provider ctr", 64'(out_prov_ctr), 64'd2);
        chk("R13 provider useful", 64'(out_prov_useful), 64'd1);
        chk("R13 no alt ctr", 64'(out_alt_ctr), 64'd0);
    endtask

    task automatic t_mask();
        hi[0] ^= 9'h1F0; h1[0] ^= 9'h1F0; h2[0] ^= 8'hF0;
        lookup();
        chk("R3 R4 bits above T1 mask ignored", 64'(out_prov_id), 64'd1);
        hi[0] ^= 9'h1F0; h1[0] ^= 9'h1F0; h2[0] ^= 8'hF0;
        h2[0] ^= 8'h01;
        lookup();
        chk("R4 shifted tag2 bit changes tag, miss", 64'(out_hit), 64'd0);
        chk("R8 fallback on tag miss", 64'(out_target), 64'(cur_fb));
        h2[0] ^= 8'h01;
    endtask

    task automatic t_longest();
        put(2, 1'b1, 2'd1, 20'h11111, 1'b0);
        put(4, 1'b1, 2'd3, 20'h44444, 1'b0);
        lookup();
        chk("R5 provider is T4", 64'(out_prov_id), 64'd4);
        chk("R5 alt is T2", 64'(out_alt_id), 64'd2);
        chk("R6 provider target", 64'(out_target), 64'(tbl_tgt(cur_pc, 20'h44444)));
        chk("R13 provider ctr 3", 64'(out_prov_ctr), 64'd3);
        chk("R13 alt ctr 1", 64'(out_alt_ctr), 64'd1);
        chk("R13 provider useful 0", 64'(out_prov_useful), 64'd0);
    endtask

    task automatic t_lowconf();
        put(4, 1'b1, 2'd0, 20'h44444, 1'b0);
        lookup();
        chk("R7 provider still T4", 64'(out_prov_id), 64'd4);
        chk("R7 alt target used", 64'(out_target), 64'(tbl_tgt(cur_pc, 20'h11111)));
        chk("R7 use_table via alt", 64'(out_use_table), 64'd1);
    endtask

    task automatic t_noalt();
        put(1, 1'b0, 2'd2, 20'hABCDE, 1'b1);
        put(2, 1'b0, 2'd1, 20'h11111, 1'b0);
        put(4, 1'b0, 2'd0, 20'h44444, 1'b0);
        put(5, 1'b1, 2'd0, 20'h55555, 1'b1);
        lookup();
        chk("R10 cleared entries gone, T5 provider", 64'(out_prov_id), 64'd5);
        chk("R7 no alt", 64'(out_alt_id), 64'd0);
        chk("R7 low conf no alt gives fallback", 64'(out_target), 64'(cur_fb));
        chk("R7 use_table 0", 64'(out_use_table), 64'd0);
        cur_fbv = 1'b0;
        lookup();
        chk("R11 ok low without table or fb", 64'(out_target_ok), 64'd0);
        cur_fbv = 1'b1;
    endtask

    task automatic t_stream();
        logic [49:0] pcs [3];
        logic [49:0] exp_t [3];
        pcs[0] = 50'h0_0000_1000_0040;
        pcs[1] = 50'h0_0000_2000_0080;
        pcs[2] = 50'h0_0000_3000_00C0;
        cur_pc = pcs[0]; put(3, 1'b1, 2'd1, 20'h30303, 1'b0);
        cur_pc = pcs[2]; put(3, 1'b1, 2'd2, 20'h0C0C0, 1'b0);
        exp_t[0] = tbl_tgt(pcs[0], 20'h30303);
        exp_t[1] = cur_fb;
        exp_t[2] = tbl_tgt(pcs[2], 20'h0C0C0);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (k >= 3) begin
                chk("R1 back-to-back valid", 64'(out_valid), 64'd1);
                chk("R1 back-to-back target", 64'(out_target), 64'(exp_t[k-3]));
            end
            if (k < 3) drive_req(pcs[k]);
            else req_valid = 1'b0;
        end
        @(negedge clk);
        chk("R1 single-cycle valid pulse", 64'(out_valid), 64'd0);
    endtask

    initial begin
        #800000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        cur_pc  = 50'h1_2345_6789_ABCD;
        cur_fb  = '0;
        cur_fbv = 1'b0;
        hi[0] = 9'h005; hi[1] = 9'h03C; hi[2] = 9'h155; hi[3] = 9'h0AA; hi[4] = 9'h1F1;
        h1[0] = 9'h009; h1[1] = 9'h0C3; h1[2] = 9'h0F0; h1[3] = 9'h111; h1[4] = 9'h07E;
        h2[0] = 8'h06;  h2[1] = 8'h5A;  h2[2] = 8'hA5;  h2[3] = 8'h3C;  h2[4] = 8'hC3;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_mask();
        t_longest();
        t_lowconf();
        t_noalt();
        t_stream();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule